// File: doc/BRIEF.md
# Synchronous Burst ROM Read Engine

This block is the device-side read path of a single-bank synchronous read-only memory. Its address bus is multiplexed between row and column. On every enabled rising clock edge it decodes a command from chip select, row strobe, column strobe and mode-set strobe. A row-activate latches a 13-bit row. A read latches a column and starts a burst. A mode-set loads the latency, burst length and beat ordering from the address pins. There is no precharge and no refresh. A new row-activate replaces the open row.

After the programmed latency, the block drives one word per enabled cycle for the length of the burst. The word is either 32 bits or 16 bits, chosen per read by an organisation select. Each data half has its own output enable. A data-mask input blanks individual beats two cycles after it is sampled. Clock enable sampled low freezes the whole engine for the following cycle. A read issued too soon after a row-activate, or with no row open, raises an error pulse and is discarded. The contents are a fixed function of row and column, so a host can check every beat without a real array.

Top module: `sburst_rom`

## Requirements
- R1: After reset, lane_oe is 00, dq is zero and cmd_err is 0. The mode is latency 6, burst length 4 and sequential order.
- R2: A command is decoded only when cs_n is low. The active-low levels of {ras_n,cas_n,mrs_n} give the command: 011 is activate, 101 is read, 110 is mode set and 111 is no operation. With cs_n high, nothing changes.
- R3: A mode set loads three fields. The length code is addr[2:0]: 010 gives 4 beats and 011 gives 8 beats. The order bit is addr[3]: 0 is sequential and 1 is interleaved. The latency is addr[6:4], which may be 4, 5 or 6. A mode set with any other length code or latency leaves the whole mode unchanged.
- R4: Take a read sampled at enabled edge E with latency L. Its first beat is visible after enabled edge E+L-1, so it is sampled at edge E+L. Before that, all lanes are disabled.
- R5: A burst gives exactly 4 or 8 beats on consecutive enabled edges. Lanes are then disabled. dq reads zero whenever lanes are disabled.
- R6: In sequential order, beat k uses column bits [b-1:0] set to (start + k) mod B. Here B is the burst length and b = log2 B. The higher column bits are kept from the start column.
- R7: In interleaved order, beat k uses column bits [b-1:0] set to start XOR k. The higher column bits are kept from the start column.
- R8: The organisation select, wide, is sampled with the read. When wide is 1, the column is addr[7:0], lane_oe is 11 and the word is {row[12:0], 000, ~col[7:0], col[7:0]}. When wide is 0, the column is addr[8:0], lane_oe is 01 and the word is {16'h0, row[6:0], col[8:0]}, so the upper half stays disabled.
- R9: dqm sampled high at enabled edge N blanks the beat driven at enabled edge N+1. That beat has lanes disabled and dq zero, and it still counts toward the burst.
- R10: cke sampled low at edge N freezes edge N+1. At that edge, outputs, mode, row and burst progress all hold.
- R11: A read needs an open row and at least RCD_MIN enabled edges since the last activate. If either condition fails, cmd_err is 1 for the next cycle and the read is discarded.
- R12: A read uses the row open when the read is issued. An activate during a burst does not change that burst. It sets the row for later reads.
- R13: An accepted read during a pending or running burst ends that burst at once. Lanes are disabled until the new burst's first beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable; low freezes the following cycle |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| mrs_n | input | 1 | Mode-set strobe, active low |
| dqm | input | 1 | Data mask, two-cycle latency |
| wide | input | 1 | Organisation select: 1 gives 32-bit words, 0 gives 16-bit words |
| addr | input | 13 | Multiplexed row, column and mode address |
| dq | output | 32 | Read data |
| lane_oe | output | 2 | Output enable per 16-bit half, bit 1 upper |
| cmd_err | output | 1 | Pulse for a read that is too early or has no open row |

## Verification
Several functions can land on the same cycle. A new read can be accepted on the very edge where an older burst would drive its next beat. The bench provokes this by issuing the second read two beats into an eight-beat burst. It judges the result by requiring every lane to be disabled from that edge until the new latency expires. A clock-enable drop can also coincide with the first beat. The bench aligns the drop so that the frozen cycle falls right after beat 0. It expects beat 0 to repeat once, with the remaining beats then shifted by one cycle. Data masks are placed on chosen beats inside the same burst windows.

// File: rtl/sburst_rom.sv
`timescale 1ns/1ps
module sburst_rom #(
  parameter int RCD_MIN = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cke,
  input  logic        cs_n,
  input  logic        ras_n,
  input  logic        cas_n,
  input  logic        mrs_n,
  input  logic        dqm,
  input  logic        wide,
  input  logic [12:0] addr,
  output logic [31:0] dq,
  output logic [1:0]  lane_oe,
  output logic        cmd_err
);
  logic        run_en, cmd_on, do_act, do_rd, do_mrs, rd_ok, mrs_ok;
  logic [12:0] row_q, b_row;
  logic        row_open;
  logic [1:0]  gap;
  logic [2:0]  cl_q, lead, idx, bmask, lo;
  logic        bl8_q, il_q, b_bl8, b_il, b_wide, busy, dqm_q, fire, last;
  logic [8:0]  b_col, col_n;
  logic [31:0] word;

  assign cmd_on = run_en & ~cs_n;
  assign do_act = cmd_on & ~ras_n &  cas_n &  mrs_n;
  assign do_rd  = cmd_on &  ras_n & ~cas_n &  mrs_n;
  assign do_mrs = cmd_on &  ras_n &  cas_n & ~mrs_n;
  assign rd_ok  = do_rd & row_open & (int'(gap) >= RCD_MIN);
  assign mrs_ok = do_mrs & (addr[2:1] == 2'b01) &
                  (addr[6:4] == 3'd4 || addr[6:4] == 3'd5 || addr[6:4] == 3'd6);

  assign bmask = b_bl8 ? 3'd7 : 3'd3;
  assign lo    = b_il ? (b_col[2:0] ^ idx) : (b_col[2:0] + idx);
  assign col_n = {b_col[8:3], (b_col[2:0] & ~bmask) | (lo & bmask)};
  assign word  = b_wide ? {b_row, 3'b000, ~col_n[7:0], col_n[7:0]}
                        : {16'h0000, b_row[6:0], col_n};
  assign fire  = (lead == 3'd1) | busy;
  assign last  = (idx == bmask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_en   <= 1'b1;
      dqm_q    <= 1'b0;
      cmd_err  <= 1'b0;
      row_q    <= '0;
      row_open <= 1'b0;
      gap      <= '0;
      cl_q     <= 3'd6;
      bl8_q    <= 1'b0;
      il_q     <= 1'b0;
      b_row    <= '0;
      b_col    <= '0;
      b_bl8    <= 1'b0;
      b_il     <= 1'b0;
      b_wide   <= 1'b0;
      lead     <= '0;
      busy     <= 1'b0;
      idx      <= '0;
      dq       <= '0;
      lane_oe  <= '0;
    end else begin
      run_en <= cke;
      if (run_en) begin
        dqm_q   <= dqm;
        cmd_err <= do_rd & ~rd_ok;
        if (do_act) begin
          row_q    <= addr;
          row_open <= 1'b1;
          gap      <= 2'd1;
        end else if (gap != 2'd3) begin
          gap <= gap + 2'd1;
        end
        if (mrs_ok) begin
          cl_q  <= addr[6:4];
          bl8_q <= addr[0];
          il_q  <= addr[3];
        end
        if (rd_ok) begin
          b_row   <= row_q;
          b_col   <= wide ? {1'b0, addr[7:0]} : addr[8:0];
          b_bl8   <= bl8_q;
          b_il    <= il_q;
          b_wide  <= wide;
          lead    <= cl_q - 3'd1;
          busy    <= 1'b0;
          idx     <= '0;
          dq      <= '0;
          lane_oe <= '0;
        end else begin
          if (lead != 3'd0) lead <= lead - 3'd1;
          if (fire) begin
            busy    <= ~last;
            idx     <= idx + 3'd1;
            dq      <= dqm_q ? 32'h0 : word;
            lane_oe <= dqm_q ? 2'b00 : {b_wide, 1'b1};
          end else begin
            dq      <= '0;
            lane_oe <= '0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/sburst_rom_chk.sv
`timescale 1ns/1ps
module sburst_rom_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cke,
  input logic        cs_n,
  input logic        ras_n,
  input logic        cas_n,
  input logic        mrs_n,
  input logic [31:0] dq,
  input logic [1:0]  lane_oe,
  input logic        cmd_err
);
  assert_upper_needs_lower_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lane_oe[1] |-> lane_oe[0]);

  assert_upper_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !lane_oe[1] |-> (dq[31:16] == 16'h0000));

  assert_suspend_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |=> ##1 ($stable(dq) && $stable(lane_oe) && $stable(cmd_err)));

  assert_err_from_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_err) |-> $past(!cs_n && ras_n && !cas_n && mrs_n));
endmodule

bind sburst_rom sburst_rom_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
  .cas_n(cas_n), .mrs_n(mrs_n), .dq(dq), .lane_oe(lane_oe), .cmd_err(cmd_err)
);

// File: tb/sburst_rom_tb.sv
`timescale 1ns/1ps
module sburst_rom_tb;
  logic clk = 1'b0, rst_n = 1'b0, cke = 1'b1, cs_n = 1'b0;
  logic ras_n = 1'b1, cas_n = 1'b1, mrs_n = 1'b1, dqm = 1'b0, wide = 1'b1;
  logic [12:0] addr = '0;
  logic [31:0] dq;
  logic [1:0]  lane_oe;
  logic        cmd_err;
  int checks = 0, errors = 0;
  bit done = 0;

  localparam logic [2:0] C_ACT = 3'b011, C_RD = 3'b101, C_MRS = 3'b110, C_NOP = 3'b111;

  logic [12:0] cur_row;
  int cur_cl, cur_bl;
  bit cur_il;

  always #2.5 clk = ~clk;

  sburst_rom u_dut (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .mrs_n(mrs_n), .dqm(dqm), .wide(wide), .addr(addr),
    .dq(dq), .lane_oe(lane_oe), .cmd_err(cmd_err)
  );

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", rq, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic drv(input logic [2:0] c, input logic [12:0] a);
    cs_n = 1'b0;
    {ras_n, cas_n, mrs_n} = c;
    addr = a;
  endtask

  task automatic issue(input logic [2:0] c, input logic [12:0] a);
    drv(c, a);
    step();
    drv(C_NOP, '0);
  endtask

  function automatic logic [31:0] exp_word(input logic [12:0] r, input logic [8:0] c, input bit w);
    return w ? {r, 3'b000, ~c[7:0], c[7:0]} : {16'h0000, r[6:0], c};
  endfunction

  function automatic logic [8:0] beat_col(input logic [8:0] c, input int bl, input bit il, input int k);
    logic [2:0] m, l;
    m = 3'(bl - 1);
    l = il ? (c[2:0] ^ 3'(k)) : (c[2:0] + 3'(k));
    return {c[8:3], (c[2:0] & ~m) | (l & m)};
  endfunction

  task automatic set_mode(input logic [12:0] a, input int cl, input int bl, input bit il);
    issue(C_MRS, a);
    cur_cl = cl; cur_bl = bl; cur_il = il;
  endtask

  task automatic activate(input logic [12:0] r);
    issue(C_ACT, r);
    cur_row = r;
    step();
  endtask

  task automatic check_off(input string rq);
    chk(lane_oe == 2'b00, rq, 32'(lane_oe), 32'h0);
    chk(dq == 32'h0, rq, dq, 32'h0);
  endtask

  task automatic burst(input logic [12:0] a, input bit w, input logic [7:0] mask,
                       input bit side_act, input logic [12:0] side_row, input string rq);
    logic [8:0] c;
    logic [12:0] r;
    c = w ? {1'b0, a[7:0]} : a[8:0];
    r = cur_row;
    wide = w;
    for (int e = 0; e <= cur_cl - 1 + cur_bl; e++) begin
      int km, kb;
      if (e == 0) drv(C_RD, a);
      else if (e == 1 && side_act) drv(C_ACT, side_row);
      else drv(C_NOP, '0);
      km = e - (cur_cl - 2);
      dqm = (km >= 0 && km < cur_bl) ? mask[km] : 1'b0;
      step();
      if (e == 0) chk(cmd_err == 1'b0, {rq, " R11 accepted read"}, 32'(cmd_err), 32'h0);
      if (e < cur_cl - 1) begin
        check_off({rq, " R4 before latency"});
      end else begin
        kb = e - (cur_cl - 1);
        if (kb == cur_bl) check_off({rq, " R5 after burst"});
        else if (mask[kb]) check_off({rq, " R9 masked beat"});
        else begin
          logic [31:0] ew;
          ew = exp_word(r, beat_col(c, cur_bl, cur_il, kb), w);
          chk(lane_oe == {w, 1'b1}, {rq, " R8 lanes"}, 32'(lane_oe), 32'({w, 1'b1}));
          chk(dq == ew, {rq, " beat data"}, dq, ew);
        end
      end
    end
    dqm = 1'b0;
    drv(C_NOP, '0);
    if (side_act) cur_row = side_row;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    step(); step();
    check_off("R1 reset");
    chk(cmd_err == 1'b0, "R1 reset err", 32'(cmd_err), 32'h0);
    rst_n = 1'b1;
    step();
    cur_cl = 6; cur_bl = 4; cur_il = 0;
    issue(C_RD, 13'h005);
    chk(cmd_err == 1'b1, "R11 read with no open row", 32'(cmd_err), 32'h1);
    step();
    chk(cmd_err == 1'b0, "R11 error is a pulse", 32'(cmd_err), 32'h0);
    for (int i = 0; i < 8; i++) begin step(); check_off("R11 discarded read"); end
    activate(13'h1A5C);
    burst(13'h012, 1'b1, 8'h00, 1'b0, '0, "R1 default mode R6");
  endtask

  task automatic t_cs();
    cs_n = 1'b1; {ras_n, cas_n, mrs_n} = C_MRS; addr = 13'h043;
    step();
    cs_n = 1'b1; {ras_n, cas_n, mrs_n} = C_RD; addr = 13'h010;
    step();
    for (int i = 0; i < 8; i++) begin
      drv(C_NOP, '0);
      step();
      check_off("R2 deselected read");
    end
    burst(13'h033, 1'b1, 8'h00, 1'b0, '0, "R2 deselected mode set");
  endtask

  task automatic t_mrs();
    set_mode(13'h043, 4, 8, 0);
    burst(13'h005, 1'b1, 8'h00, 1'b0, '0, "R3 R4 R6 cl4 bl8 seq");
    issue(C_MRS, 13'h073);
    issue(C_MRS, 13'h041);
    issue(C_MRS, 13'h03B);
    burst(13'h0F1, 1'b1, 8'h00, 1'b0, '0, "R3 unsupported ignored");
  endtask

  task automatic t_il();
    set_mode(13'h05B, 5, 8, 1);
    burst(13'h02B, 1'b1, 8'h00, 1'b0, '0, "R7 cl5 bl8 interleave");
    set_mode(13'h06A, 6, 4, 1);
    burst(13'h006, 1'b1, 8'h00, 1'b0, '0, "R7 cl6 bl4 interleave");
  endtask

  task automatic t_x16();
    set_mode(13'h042, 4, 4, 0);
    burst(13'h1FE, 1'b0, 8'h00, 1'b0, '0, "R8 x16 nine-bit column");
    burst(13'h1FE, 1'b1, 8'h00, 1'b0, '0, "R8 x32 eight-bit column");
  endtask

  task automatic t_dqm();
    set_mode(13'h053, 5, 8, 0);
    burst(13'h010, 1'b1, 8'b0010_0110, 1'b0, '0, "R9 mask beats 1 2 5");
    set_mode(13'h042, 4, 4, 0);
    burst(13'h0A1, 1'b0, 8'b0000_1001, 1'b0, '0, "R9 x16 mask first and last");
  endtask

  task automatic t_cke();
    logic [31:0] ew [4];
    set_mode(13'h042, 4, 4, 0);
    wide = 1'b1;
    for (int k = 0; k < 4; k++) ew[k] = exp_word(cur_row, beat_col(9'h040, 4, 0, k), 1'b1);
    issue(C_RD, 13'h040);
    check_off("R10 before latency");
    step(); check_off("R10 before latency");
    step(); check_off("R10 before latency");
    cke = 1'b0;
    step();
    chk(dq == ew[0], "R10 beat0", dq, ew[0]);
    cke = 1'b1;
    step();
    chk(dq == ew[0], "R10 frozen cycle holds beat0", dq, ew[0]);
    chk(lane_oe == 2'b11, "R10 frozen cycle holds lanes", 32'(lane_oe), 32'h3);
    for (int k = 1; k < 4; k++) begin
      step();
      chk(dq == ew[k], "R10 beat after suspend", dq, ew[k]);
    end
    step();
    check_off("R10 R5 end after suspend");
  endtask

  task automatic t_rcd();
    set_mode(13'h042, 4, 4, 0);
    issue(C_ACT, 13'h0777);
    cur_row = 13'h0777;
    issue(C_RD, 13'h003);
    chk(cmd_err == 1'b1, "R11 read one edge after activate", 32'(cmd_err), 32'h1);
    step();
    chk(cmd_err == 1'b0, "R11 error clears", 32'(cmd_err), 32'h0);
    for (int i = 0; i < 5; i++) begin step(); check_off("R11 early read discarded"); end
    issue(C_ACT, 13'h0555);
    cur_row = 13'h0555;
    issue(C_NOP, '0);
    burst(13'h00C, 1'b1, 8'h00, 1'b0, '0, "R11 read at minimum gap");
  endtask

  task automatic t_row();
    logic [31:0] ew;
    set_mode(13'h043, 4, 8, 0);
    activate(13'h0123);
    step();
    burst(13'h000, 1'b1, 8'h00, 1'b1, 13'h1F00, "R12 activate during burst");
    burst(13'h000, 1'b1, 8'h00, 1'b0, '0, "R12 new row used");
    wide = 1'b1;
    issue(C_RD, 13'h008);
    check_off("R13 first read pending");
    step(); check_off("R13 first read pending");
    step(); check_off("R13 first read pending");
    step();
    ew = exp_word(cur_row, 9'h008, 1'b1);
    chk(dq == ew, "R13 first burst beat0", dq, ew);
    step();
    ew = exp_word(cur_row, 9'h009, 1'b1);
    chk(dq == ew, "R13 first burst beat1", dq, ew);
    burst(13'h020, 1'b1, 8'h00, 1'b0, '0, "R13 restart");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: all requirements, actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    step();
    t_reset();
    t_cs();
    t_mrs();
    t_il();
    t_x16();
    t_dqm();
    t_cke();
    t_rcd();
    t_row();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule